// File: doc/BRIEF.md
# Repacking Stream Buffer with Burst Threshold

This block sits between the read side and the write side of one DMA stream. It holds up to four 32-bit words, stored as sixteen byte slots in a ring. Items arrive from the source side as bytes, half-words or words and leave on the destination side in a size chosen on its own. When the two sizes differ, the block splits or joins items in little-endian order: the first byte stored goes out on the lowest byte lane.

A two-bit field sets a fill level. When the stored byte count reaches that level, `burst_rdy` rises, and the destination side may then begin a burst. At the end of a transfer, `flush` lets a final partial item leave, with byte enables that mark its valid lanes.

In direct mode the ring is bypassed. A single holding register takes one item ahead of demand, so that a request from the peripheral is met at once. Two sticky flags record misuse:
- one in buffered mode, for a push into a full buffer or a pop from an empty one;
- one in direct mode, for a new item offered while the held item is still waiting.

Both sides use valid/ready handshakes. The size and mode inputs may change only while the block is empty.

Top module: `pack_fifo`

## Requirements
- R1: After reset the block is empty: `src_ready`=1, `dst_valid`=0, `burst_rdy`=0, `fifo_err`=0, `dm_err`=0.
- R2: In buffered mode (`direct_mode`=0) the block holds at most 16 bytes. `src_ready` is high exactly when the free space is at least one source item, so four word pushes make it fall.
- R3: With byte sources and word destinations, four source bytes b0..b3 leave as one word {b3,b2,b1,b0}, with b0 in bits 7:0 and `dst_be`=4'b1111.
- R4: With word sources and byte destinations, one source word leaves as four bytes, lowest lane first, each in bits 7:0 with `dst_be`=4'b0001.
- R5: Size encoding for `src_size` and `dst_size`: 00 is a byte, 01 is a half-word, 10 and 11 are a word. Without flush, `dst_valid` is high only when at least one whole destination item is stored, and bytes leave in the order they arrived.
- R6: `burst_rdy` is high in buffered mode exactly when the stored bytes reach the level set by `thr_sel`: 00 gives 4 bytes (1/4), 01 gives 8 (1/2), 10 gives 12 (3/4), 11 gives 16 (full). It is low in direct mode.
- R7: While `flush` is high and fewer bytes than one destination item remain (but at least one), those k bytes leave as one item in lanes 0..k-1. `dst_be` then has its k low bits set, and the unused lanes are zero.
- R8: Every delivered item has a non-zero `dst_be` whose set bits form a run starting at lane 0.
- R9: In direct mode one source item is held and offered at once, as the full `src_data` word with `dst_be` taken from `src_size`. `dst_size` is ignored, and `src_ready` stays low until the held item is taken.
- R10: `fifo_err` sets in buffered mode when `src_valid` is high while `src_ready` is low, or when `dst_ready` is high while `dst_valid` is low. It stays set until reset, and the rejected push is not stored.
- R11: `dm_err` sets in direct mode when `src_valid` is high while an item is held. The held item is kept unchanged, and the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| direct_mode | input | 1 | 1 selects the single-item bypass |
| src_size | input | 2 | Source item size code |
| dst_size | input | 2 | Destination item size code |
| thr_sel | input | 2 | Fill level for `burst_rdy` |
| flush | input | 1 | Lets a final partial item leave |
| src_valid | input | 1 | Source item offered |
| src_ready | output | 1 | Source item can be accepted |
| src_data | input | 32 | Source item, right-aligned |
| dst_valid | output | 1 | Destination item available |
| dst_ready | input | 1 | Destination takes the item |
| dst_data | output | 32 | Destination item, right-aligned |
| dst_be | output | 4 | Valid byte lanes of `dst_data` |
| burst_rdy | output | 1 | Fill level reached |
| fifo_err | output | 1 | Sticky buffered-mode misuse flag |
| dm_err | output | 1 | Sticky direct-mode misuse flag |

## Verification
On every cycle the assertions check these properties:
- the byte count never exceeds the capacity, and a pop never takes more bytes than are stored;
- `burst_rdy` never appears without a deliverable item;
- byte enables always form a run starting at lane 0;
- a held direct-mode item stays unchanged while it is not taken;
- both error flags are sticky.

Only the bench's scenarios can show that bytes come out in their arrival order for each pairing of sizes, and that a flush tail is masked correctly. The same holds for the exact point at which each threshold setting and the full condition are reached, and for the fact that a rejected push leaves no trace in the data stream.

// File: rtl/pf_pkg.sv
package pf_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WIDE = 2'b11
   } item_size_e;

   // number of bytes in one item of the given size code
   function automatic logic [2:0] item_bytes(input logic [1:0] code);
      case (item_size_e'(code))
         SZ_BYTE: item_bytes = 3'd1;
         SZ_HALF: item_bytes = 3'd2;
         default: item_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/pf_lane_mask.sv
module pf_lane_mask #(
   parameter int LANES = 4,
   parameter int NW    = 3
) (
   input  logic [NW-1:0]    n,
   output logic [LANES-1:0] mask
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mask[i] = (NW'(i) < n);
   end
endmodule

// File: rtl/pf_byte_ring.sv
module pf_byte_ring #(
   parameter int WORDS = 4,
   parameter int LANES = 4,
   localparam int CAP_B = WORDS * LANES,
   localparam int PW    = $clog2(CAP_B),
   localparam int CW    = $clog2(CAP_B + 1),
   localparam int DW    = 8 * LANES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [CW-1:0] push_n,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   input  logic [CW-1:0] pop_n,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count
);
   if ((CAP_B & (CAP_B - 1)) != 0) begin : g_bad_cap
      $error("pf_byte_ring: byte capacity must be a power of two");
   end

   logic [7:0]    mem [CAP_B];
   logic [PW-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (push && (CW'(i) < push_n)) begin
            mem[wr_ptr + PW'(i)] <= push_data[8*i +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PW'(push_n);
         if (pop)  rd_ptr <= rd_ptr + PW'(pop_n);
         count <= count + (push ? push_n : '0) - (pop ? pop_n : '0);
      end
   end

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         rd_data[8*i +: 8] = mem[rd_ptr + PW'(i)];
      end
   end

   // R2: stored bytes never exceed the capacity
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(CAP_B));

   // R5: a pop never removes more bytes than are stored
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (pop_n <= count));

endmodule

// File: rtl/pf_direct_slot.sv
module pf_direct_slot #(
   parameter int LANES = 4,
   localparam int DW = 8 * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             src_valid,
   input  logic [DW-1:0]    src_data,
   input  logic [LANES-1:0] src_be,
   input  logic             dst_ready,
   output logic             ready,
   output logic             occ,
   output logic [DW-1:0]    data,
   output logic [LANES-1:0] be,
   output logic             err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ  <= 1'b0;
         data <= '0;
         be   <= '0;
         err  <= 1'b0;
      end else begin
         if (en && src_valid && !occ) begin
            occ  <= 1'b1;
            data <= src_data;
            be   <= src_be;
         end else if (en && occ && dst_ready) begin
            occ <= 1'b0;
         end
         if (en && src_valid && occ) err <= 1'b1;
      end
   end

   assign ready = en && !occ;

   // R9: a held item is not lost or altered while it waits
   a_r9_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && occ && !dst_ready) |=> (occ && data == $past(data)));

   // R11: the direct-mode error flag is sticky
   a_r11_dm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

endmodule

// File: rtl/pack_fifo.sv
module pack_fifo #(
   parameter int WORDS     = 4,
   parameter int LANES     = 4,
   parameter bit DIRECT_EN = 1'b1,
   localparam int CAP_B = WORDS * LANES,
   localparam int CW    = $clog2(CAP_B + 1),
   localparam int DW    = 8 * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             direct_mode,
   input  logic [1:0]       src_size,
   input  logic [1:0]       dst_size,
   input  logic [1:0]       thr_sel,
   input  logic             flush,
   input  logic             src_valid,
   output logic             src_ready,
   input  logic [DW-1:0]    src_data,
   output logic             dst_valid,
   input  logic             dst_ready,
   output logic [DW-1:0]    dst_data,
   output logic [LANES-1:0] dst_be,
   output logic             burst_rdy,
   output logic             fifo_err,
   output logic             dm_err
);
   import pf_pkg::*;

   if (LANES < 4) begin : g_bad_lanes
      $error("pack_fifo: a word item needs at least four lanes");
   end
   if (WORDS < 1) begin : g_bad_words
      $error("pack_fifo: at least one word of storage is needed");
   end

   logic [CW-1:0]    sb, db, count, free, avail, thr_b;
   logic [DW-1:0]    rd_data, f_data;
   logic [LANES-1:0] f_be, s_be;
   logic             f_src_ready, f_dst_valid, push, pop;

   assign sb    = CW'(item_bytes(src_size));
   assign db    = CW'(item_bytes(dst_size));
   assign free  = CW'(CAP_B) - count;
   assign thr_b = CW'((32'(thr_sel) + 32'd1) * (CAP_B / 4));

   assign f_src_ready = (free >= sb);
   assign f_dst_valid = (count >= db) || (flush && count != '0);
   assign avail       = (count >= db) ? db : count;
   assign push        = !direct_mode && src_valid && f_src_ready;
   assign pop         = !direct_mode && dst_ready && f_dst_valid;

   pf_byte_ring #(.WORDS(WORDS), .LANES(LANES)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_n    (sb),
      .push_data (src_data),
      .pop       (pop),
      .pop_n     (avail),
      .rd_data   (rd_data),
      .count     (count)
   );

   pf_lane_mask #(.LANES(LANES), .NW(CW)) u_out_mask (.n(avail), .mask(f_be));
   pf_lane_mask #(.LANES(LANES), .NW(CW)) u_in_mask  (.n(sb),    .mask(s_be));

   for (genvar i = 0; i < LANES; i++) begin : g_out_lane
      assign f_data[8*i +: 8] = f_be[i] ? rd_data[8*i +: 8] : 8'h00;
   end

   logic             d_ready, d_occ, d_err;
   logic [DW-1:0]    d_data;
   logic [LANES-1:0] d_be;

   if (DIRECT_EN) begin : g_direct
      pf_direct_slot #(.LANES(LANES)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (direct_mode),
         .src_valid (src_valid),
         .src_data  (src_data),
         .src_be    (s_be),
         .dst_ready (dst_ready),
         .ready     (d_ready),
         .occ       (d_occ),
         .data      (d_data),
         .be        (d_be),
         .err       (d_err)
      );
   end else begin : g_no_direct
      assign d_ready = 1'b0;
      assign d_occ   = 1'b0;
      assign d_data  = '0;
      assign d_be    = '0;
      assign d_err   = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_err <= 1'b0;
      end else if (!direct_mode &&
                   ((src_valid && !f_src_ready) || (dst_ready && !f_dst_valid))) begin
         fifo_err <= 1'b1;
      end
   end

   assign src_ready = direct_mode ? d_ready : f_src_ready;
   assign dst_valid = direct_mode ? d_occ   : f_dst_valid;
   assign dst_data  = direct_mode ? d_data  : f_data;
   assign dst_be    = direct_mode ? d_be    : f_be;
   assign burst_rdy = !direct_mode && (count >= thr_b);
   assign dm_err    = d_err;

   // R6: the fill level always covers at least one destination item
   a_r6_burst_has_item: assert property (@(posedge clk) disable iff (!rst_n)
      burst_rdy |-> dst_valid);

   // R8: byte enables form a run that starts at lane 0
   a_r8_be_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid |-> (dst_be != '0 && ((dst_be & (dst_be + 1'b1)) == '0)));

   // R10: the buffered-mode error flag is sticky
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_err |=> fifo_err);

endmodule

// File: tb/pack_fifo_bench.sv
module pack_fifo_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        direct_mode = 1'b0;
   logic [1:0]  src_size = 2'b10, dst_size = 2'b10, thr_sel = 2'b01;
   logic        flush = 1'b0, src_valid = 1'b0;
   logic [31:0] src_data = '0;
   logic        src_ready, dst_valid, burst_rdy, fifo_err, dm_err;
   logic [31:0] dst_data;
   logic [3:0]  dst_be;
   logic        mon_rdy = 1'b0, force_rdy = 1'b0, mon_en = 1'b0;
   logic        dst_ready;
   assign dst_ready = mon_rdy | force_rdy;

   int    n_run = 0, n_fail = 0;
   string cur_req = "R1";
   logic [7:0]  bq[$];
   logic [35:0] wq[$];

   always #4 clk = ~clk;

   pack_fifo u_pack_fifo (
      .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode),
      .src_size(src_size), .dst_size(dst_size), .thr_sel(thr_sel),
      .flush(flush), .src_valid(src_valid), .src_ready(src_ready),
      .src_data(src_data), .dst_valid(dst_valid), .dst_ready(dst_ready),
      .dst_data(dst_data), .dst_be(dst_be), .burst_rdy(burst_rdy),
      .fifo_err(fifo_err), .dm_err(dm_err)
   );

   function automatic int nbytes(input logic [1:0] c);
      return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor / scoreboard: pops expected bytes or items as the design delivers
   initial forever begin
      @(negedge clk); #1;
      mon_rdy = 1'b0;
      if (rst_n) begin
         if (mon_en && dst_valid) begin
            if (direct_mode) begin
               if (wq.size() == 0) chk(0, cur_req, "unexpected item", dst_data, 0);
               else begin
                  logic [35:0] e;
                  e = wq.pop_front();
                  chk(dst_data == e[31:0], cur_req, "direct data", dst_data, e[31:0]);
                  chk(dst_be == e[35:32], cur_req, "direct be", {28'd0, dst_be}, {28'd0, e[35:32]});
               end
            end else begin
               int db, n;
               logic [31:0] ed;
               logic [3:0]  eb;
               db = nbytes(dst_size);
               n  = (bq.size() >= db) ? db : (flush ? bq.size() : 0);
               if (n == 0) chk(0, cur_req, "valid without bytes", dst_data, 0);
               else begin
                  ed = '0;
                  for (int k = 0; k < n; k++) ed[8*k +: 8] = bq.pop_front();
                  eb = 4'((1 << n) - 1);
                  chk(dst_data == ed, cur_req, "data", dst_data, ed);
                  chk(dst_be == eb, cur_req, "be", {28'd0, dst_be}, {28'd0, eb});
               end
            end
            mon_rdy = 1'b1;
         end
         if (src_valid && src_ready) begin
            if (direct_mode) begin
               logic [3:0] m;
               m = 4'((1 << nbytes(src_size)) - 1);
               wq.push_back({m, src_data});
            end else begin
               for (int k = 0; k < nbytes(src_size); k++) bq.push_back(src_data[8*k +: 8]);
            end
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0; mon_en = 1'b0; force_rdy = 1'b0; src_valid = 1'b0;
      flush = 1'b0; direct_mode = 1'b0;
      bq.delete(); wq.delete();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input logic [31:0] d);
      @(negedge clk);
      while (!src_ready) @(negedge clk);
      src_valid = 1'b1; src_data = d;
      @(negedge clk);
      src_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset(); #2;
      chk(src_ready == 1, "R1", "src_ready", src_ready, 1);
      chk(dst_valid == 0, "R1", "dst_valid", dst_valid, 0);
      chk(burst_rdy == 0, "R1", "burst_rdy", burst_rdy, 0);
      chk(fifo_err == 0 && dm_err == 0, "R1", "flags", {fifo_err, dm_err}, 0);

      // R2 R6: fill with words, sweep levels, overflow attempt (R10)
      src_size = 2'b10; dst_size = 2'b10;
      for (int w = 1; w <= 4; w++) begin
         send(32'h1000_0000 + w); #2;
         for (int s = 0; s < 4; s++) begin
            thr_sel = 2'(s); #1;
            chk(burst_rdy == (4*w >= 4*(s+1)), "R6", "burst_rdy", burst_rdy, (4*w >= 4*(s+1)));
         end
         chk(src_ready == (w < 4), "R2", "src_ready", src_ready, (w < 4));
      end
      @(negedge clk); src_valid = 1'b1; src_data = 32'hBAD0_BAD0;
      @(negedge clk); src_valid = 1'b0; #2;
      chk(fifo_err == 1, "R10", "overflow flag", fifo_err, 1);
      idle(3);
      chk(fifo_err == 1, "R10", "flag sticky", fifo_err, 1);
      cur_req = "R5"; mon_en = 1'b1;
      idle(12);
      chk(bq.size() == 0, "R10", "rejected push left bytes", bq.size(), 0);
      chk(dst_valid == 0, "R5", "empty after drain", dst_valid, 0);

      // R3 R8: byte source, word destination
      do_reset(); cur_req = "R3 R8"; mon_en = 1'b1;
      src_size = 2'b00; dst_size = 2'b10;
      for (int b = 0; b < 8; b++) send(32'hFFFF_FF00 | 32'(8'h11 * (b + 1)));
      idle(4);
      chk(bq.size() == 0, "R3", "bytes drained", bq.size(), 0);

      // R4: word source, byte destination
      cur_req = "R4"; src_size = 2'b10; dst_size = 2'b00;
      send(32'hA1B2_C3D4); send(32'h0F1E_2D3C);
      idle(12);
      chk(bq.size() == 0, "R4", "bytes drained", bq.size(), 0);

      // R5: half source into word, byte source into half
      cur_req = "R5"; src_size = 2'b01; dst_size = 2'b10;
      send(32'h1111_BEEF); send(32'h2222_CAFE);
      idle(4);
      src_size = 2'b00; dst_size = 2'b01;
      send(32'h0000_0001); send(32'h0000_0002); send(32'h0000_0003);
      idle(4);
      chk(dst_valid == 0, "R5", "no valid on a partial half", dst_valid, 0);

      // R7: flush tail
      do_reset(); cur_req = "R7"; mon_en = 1'b1;
      src_size = 2'b00; dst_size = 2'b10;
      send(32'hAA); send(32'hBB); send(32'hCC);
      idle(3);
      chk(dst_valid == 0, "R5", "held without flush", dst_valid, 0);
      flush = 1'b1;
      idle(3);
      flush = 1'b0;
      chk(bq.size() == 0, "R7", "tail drained", bq.size(), 0);

      // R10: underrun
      do_reset();
      @(negedge clk); force_rdy = 1'b1;
      @(negedge clk); force_rdy = 1'b0; #2;
      chk(fifo_err == 1, "R10", "underrun flag", fifo_err, 1);

      // R9: direct mode preload
      do_reset(); direct_mode = 1'b1; cur_req = "R9";
      src_size = 2'b01; dst_size = 2'b00;
      send(32'hDEAD_BEEF); #2;
      chk(dst_valid == 1, "R9", "preloaded", dst_valid, 1);
      chk(dst_data == 32'hDEAD_BEEF, "R9", "data", dst_data, 32'hDEAD_BEEF);
      chk(dst_be == 4'b0011, "R9", "be", dst_be, 4'b0011);
      chk(src_ready == 0, "R9", "busy", src_ready, 0);
      chk(burst_rdy == 0, "R6", "no level in direct", burst_rdy, 0);
      mon_en = 1'b1; idle(3);
      src_size = 2'b10; send(32'h1234_5678); idle(3);
      chk(wq.size() == 0, "R9", "items drained", wq.size(), 0);

      // R11: second item while held
      mon_en = 1'b0; cur_req = "R11";
      send(32'h55AA_55AA);
      @(negedge clk); src_valid = 1'b1; src_data = 32'h0000_0099;
      @(negedge clk); src_valid = 1'b0; #2;
      chk(dm_err == 1, "R11", "flag", dm_err, 1);
      chk(dst_data == 32'h55AA_55AA, "R11", "held kept", dst_data, 32'h55AA_55AA);
      chk(fifo_err == 0, "R10", "no buffered flag in direct", fifo_err, 0);
      mon_en = 1'b1; idle(4);
      chk(dm_err == 1, "R11", "sticky", dm_err, 1);
      chk(wq.size() == 0, "R11", "held item delivered", wq.size(), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule